// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Core

This block is the host-facing register layer of a two-channel asynchronous serial controller. A byte-wide bus reaches four locations: a control port and a data port for each of the two channels. Control accesses go through a per-channel register pointer, so one port reaches a whole bank of configuration and status registers. The data port hands received bytes to the host and takes bytes to send. The bit-level line engine sits outside the block. It offers received bytes on `rx_valid`/`rx_byte`, reports line breaks on `brk_in`, takes outgoing bytes from the `tx_valid` strobe and answers with `tx_done`.

The block tracks receive and transmit interrupt requests for each channel. Each request has an in-service flag, and the two flags of a channel lock each other out. The block keeps one interrupt vector shared by both channels. Its encoding depends on a status-high option bit. A pending register, read through channel A, shows the requests of both channels. Register 0 carries commands that end interrupt service. The master register resets one channel or both. The block also decodes the line settings into output signals: clock divisor, parity, stop bits and character length.

Channel index 0 is channel B and index 1 is channel A. With `ADDR_SHIFT` = 0, address bit 0 selects data (1) or control (0), and address bit 1 selects channel A (1) or channel B (0).

Top module: `dual_serial_intc`

## Requirements
- R1: A control write while the pointer is 0 loads pointer bits 2:0 from data bits 2:0. Command field 5:3 equal to 001 also sets pointer bit 3. Any control read or write of a register other than 0 returns the pointer to 0. Control reads return the register the pointer selects.
- R2: After reset, status register 0 reads 0x44 on each channel (bit 2 transmit-empty, bit 6 underrun). Register 1 reads 0x07 (bit 0 all-sent, bits 2:1 = 11). Register 2 reads 0x00 and `irq` is low. The line settings decode to divisor 4, no parity, one stop bit and 5 data bits.
- R3: `rx_ready` equals register 3 bit 0 (receive enable) AND NOT receive-available (register 0 bit 0). A byte offered while `rx_ready` is low is dropped. A data-port read returns the held byte and clears receive-available.
- R4: A data-port write with register 5 bit 3 (transmit enable) set gives a one-cycle `tx_valid` with the byte, and clears register 0 bit 2 and register 1 bit 0. `tx_done` sets both bits again. With transmit disabled, a data write gives no strobe and leaves the status unchanged.
- R5: A channel requests an interrupt in any of three cases: register 1 bit 1 is set with a transmit request pending; register 1 bits 4:3 are 01 or 10 with a receive request pending; register 15 bit 7 is set with break status. Receive mode 11 gives no request. `irq` is the OR of both channels.
- R6: Vector codes with register 9 bit 4 set: receive A 0x30, receive B 0x20, transmit A 0x10, none 0x60. With the bit clear: 0x0C, 0x04, 0x08 and 0x06. Transmit B is always 0x00. A new request loads the vector only if the other request type of that channel is not in service.
- R7: Register 3 read through channel A gives the pending requests: bit 5 receive A, bit 4 transmit A, bit 2 receive B, bit 1 transmit B. Read through channel B it gives 0.
- R8: Command 101 (write 0x28) clears the transmit request. Command 111 (write 0x38) ends receive service if it is active, and otherwise ends transmit service. Ending one service sets the vector to "none", or to the other request if that request is still pending.
- R9: Register 9 bits 7:6 reset channels: 01 resets B, 10 resets A, 11 resets both. A reset of B also clears the vector. The other channel keeps its state.
- R10: `brk_in` sets register 0 bit 7. Only a channel reset clears it.
- R11: `baud_div` = 2 × (time constant + 2) × clock factor. The time constant is {register 13, register 12}. The clock factor is 1, 16, 32 or 64 for register 4 bits 7:6 = 00, 01, 10, 11. Register 4 bit 0 enables parity, bit 1 selects even parity, and bits 3:2 = 11 select two stop bits. Register 5 bits 6:5 = 00, 01, 10, 11 give 5, 7, 6 and 8 data bits.
- R12: Within one channel, receive service and transmit service are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Data/control select and channel select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rx_valid | input | 2 | Received byte offered, per channel |
| rx_byte | input | 16 | Received bytes, channel i in bits 8i+7:8i |
| rx_ready | output | 2 | Channel accepts a byte |
| brk_in | input | 2 | Break detected, per channel |
| tx_valid | output | 2 | One-cycle byte-to-send strobe |
| tx_byte | output | 16 | Byte to send, per channel |
| tx_done | input | 2 | Line engine finished the byte |
| irq | output | 1 | Combined interrupt |
| baud_div | output | 48 | Input-clock divisor, 24 bits per channel |
| par_en | output | 2 | Parity enabled |
| par_even | output | 2 | Even parity |
| stop_two | output | 2 | Two stop bits |
| data_bits | output | 8 | Character length, 4 bits per channel |

## Verification
The hardest state to reach is the lockout case, where one channel has a transmit request in service and a receive request arrives behind it. The bench gets there in steps. It enables both interrupt types on channel A, sends a byte and returns `tx_done`, then offers a received byte. It then checks that the vector still shows transmit service while the pending register shows both requests. Next it issues the end-of-service command and expects the vector to move to the receive code. Finally a data read returns the vector to the "none" code.

// File: rtl/dual_serial_intc.sv
module dual_serial_intc #(
  parameter int ADDR_SHIFT = 0,
  parameter int ADDR_W = ADDR_SHIFT + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        rx_valid,
  input  logic [15:0]       rx_byte,
  output logic [1:0]        rx_ready,
  input  logic [1:0]        brk_in,
  output logic [1:0]        tx_valid,
  output logic [15:0]       tx_byte,
  input  logic [1:0]        tx_done,
  output logic              irq,
  output logic [47:0]       baud_div,
  output logic [1:0]        par_en,
  output logic [1:0]        par_even,
  output logic [1:0]        stop_two,
  output logic [7:0]        data_bits
);
  localparam int DIV_W = 24;

  typedef struct packed {
    logic [7:0] ie, rxc, lc, txc, tcl, tch, ext, rxb, txb;
    logic [3:0] ptr;
    logic rxav, txe, sent, brk, rxi, txi, rxs, txs, txv;
  } chan_t;

  localparam chan_t CH_RST = '{lc: 8'h04, txe: 1'b1, sent: 1'b1, default: '0};

  chan_t [1:0] c_q, c_d;
  logic [7:0] vec_q, vec_d;
  logic sthi_q, sthi_d;
  logic [1:0] crst, clr_rx, clr_tx;
  logic [1:0] txe_v, rxi_v, txi_v, rxs_v, txs_v, brk_v, chirq;
  logic bch, dsel;
  logic [3:0] cur_ptr;

  assign dsel    = bus_addr[ADDR_SHIFT];
  assign bch     = bus_addr[ADDR_SHIFT+1];
  assign cur_ptr = c_q[bch].ptr;

  function automatic logic [7:0] vcode(input logic sh, input logic is_tx, input logic is_a, input logic none);
    if (none) return sh ? 8'h60 : 8'h06;
    if (is_tx) return is_a ? (sh ? 8'h10 : 8'h08) : 8'h00;
    return is_a ? (sh ? 8'h30 : 8'h0C) : (sh ? 8'h20 : 8'h04);
  endfunction

  always_comb begin
    c_d = c_q; vec_d = vec_q; sthi_d = sthi_q;
    crst = '0; clr_rx = '0; clr_tx = '0;
    for (int i = 0; i < 2; i++) begin
      c_d[i].txv = 1'b0;
      if (tx_done[i]) begin
        c_d[i].txe = 1'b1; c_d[i].sent = 1'b1; c_d[i].txi = 1'b1;
        if (!c_d[i].rxs) begin
          c_d[i].txs = 1'b1; vec_d = vcode(sthi_q, 1'b1, i == 1, 1'b0);
        end
      end
    end
    if (bus_sel) begin
      if (dsel) begin
        if (bus_wr) begin
          c_d[bch].txb = bus_wdata;
          if (c_q[bch].txc[3]) begin
            c_d[bch].txe = 1'b0; c_d[bch].sent = 1'b0; c_d[bch].txv = 1'b1;
          end
        end else begin
          c_d[bch].rxav = 1'b0; clr_rx[bch] = 1'b1;
        end
      end else begin
        if (cur_ptr != 4'd0) c_d[bch].ptr = 4'd0;
        if (bus_wr) begin
          if (cur_ptr == 4'd0) begin
            c_d[bch].ptr = {bus_wdata[5:3] == 3'd1, bus_wdata[2:0]};
            if (bus_wdata[5:3] == 3'd5) clr_tx[bch] = 1'b1;
            else if (bus_wdata[5:3] == 3'd7) begin
              if (c_q[bch].rxs) clr_rx[bch] = 1'b1;
              else if (c_q[bch].txs) clr_tx[bch] = 1'b1;
            end
          end else begin
            case (cur_ptr)
              4'd1:  c_d[bch].ie  = bus_wdata;
              4'd2:  vec_d        = bus_wdata;
              4'd3:  c_d[bch].rxc = bus_wdata;
              4'd4:  c_d[bch].lc  = bus_wdata;
              4'd5:  c_d[bch].txc = bus_wdata;
              4'd9:  begin sthi_d = bus_wdata[4]; crst = bus_wdata[7:6]; end
              4'd12: c_d[bch].tcl = bus_wdata;
              4'd13: c_d[bch].tch = bus_wdata;
              4'd15: c_d[bch].ext = bus_wdata;
              default: ;
            endcase
          end
        end
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (clr_rx[i]) begin
        c_d[i].rxi = 1'b0; c_d[i].rxs = 1'b0;
        vec_d = vcode(sthi_q, 1'b0, i == 1, 1'b1);
        if (c_d[i].txi) begin
          c_d[i].txs = 1'b1; vec_d = vcode(sthi_q, 1'b1, i == 1, 1'b0);
        end
      end
      if (clr_tx[i]) begin
        c_d[i].txi = 1'b0; c_d[i].txs = 1'b0;
        vec_d = vcode(sthi_q, 1'b0, i == 1, 1'b1);
        if (c_d[i].rxi) begin
          c_d[i].rxs = 1'b1; vec_d = vcode(sthi_q, 1'b0, i == 1, 1'b0);
        end
      end
      if (rx_valid[i] && rx_ready[i]) begin
        c_d[i].rxb = rx_byte[i*8 +: 8]; c_d[i].rxav = 1'b1; c_d[i].rxi = 1'b1;
        if (!c_d[i].txs) begin
          c_d[i].rxs = 1'b1; vec_d = vcode(sthi_q, 1'b0, i == 1, 1'b0);
        end
      end
      if (brk_in[i]) c_d[i].brk = 1'b1;
      if (crst[i]) c_d[i] = CH_RST;
    end
    if (crst[0]) vec_d = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= {CH_RST, CH_RST};
      vec_q <= 8'h00;
      sthi_q <= 1'b0;
    end else begin
      c_q <= c_d;
      vec_q <= vec_d;
      sthi_q <= sthi_d;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [DIV_W-1:0] base;
    logic [2:0] sh;
    assign base = {8'd0, c_q[g].tch, c_q[g].tcl} + DIV_W'(2);
    always_comb begin
      case (c_q[g].lc[7:6])
        2'b00:   sh = 3'd1;
        2'b01:   sh = 3'd5;
        2'b10:   sh = 3'd6;
        default: sh = 3'd7;
      endcase
    end
    always_comb begin
      case (c_q[g].txc[6:5])
        2'b00:   data_bits[g*4 +: 4] = 4'd5;
        2'b01:   data_bits[g*4 +: 4] = 4'd7;
        2'b10:   data_bits[g*4 +: 4] = 4'd6;
        default: data_bits[g*4 +: 4] = 4'd8;
      endcase
    end
    assign baud_div[g*DIV_W +: DIV_W] = base << sh;
    assign par_en[g]   = c_q[g].lc[0];
    assign par_even[g] = c_q[g].lc[1];
    assign stop_two[g] = c_q[g].lc[3:2] == 2'b11;
    assign rx_ready[g] = c_q[g].rxc[0] & ~c_q[g].rxav;
    assign tx_valid[g] = c_q[g].txv;
    assign tx_byte[g*8 +: 8] = c_q[g].txb;
    assign txe_v[g] = c_q[g].txe;
    assign rxi_v[g] = c_q[g].rxi;
    assign txi_v[g] = c_q[g].txi;
    assign rxs_v[g] = c_q[g].rxs;
    assign txs_v[g] = c_q[g].txs;
    assign brk_v[g] = c_q[g].brk;
    assign chirq[g] = (c_q[g].ie[1] & c_q[g].txi)
                    | ((c_q[g].ie[4:3] == 2'b01 || c_q[g].ie[4:3] == 2'b10) & c_q[g].rxi)
                    | (c_q[g].ext[7] & c_q[g].brk);
  end

  assign irq = |chirq;

  always_comb begin
    bus_rdata = 8'h00;
    if (dsel) bus_rdata = c_q[bch].rxb;
    else begin
      case (cur_ptr)
        4'd0: bus_rdata = {c_q[bch].brk, 1'b1, 3'b000, c_q[bch].txe, 1'b0, c_q[bch].rxav};
        4'd1: bus_rdata = {5'b00000, 2'b11, c_q[bch].sent};
        4'd2: bus_rdata = vec_q;
        4'd3: bus_rdata = bch ? {2'b00, rxi_v[1], txi_v[1], 1'b0, rxi_v[0], txi_v[0], 1'b0} : 8'h00;
        default: bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

module dual_serial_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic [1:0] rx_valid,
  input logic [1:0] rx_ready,
  input logic [1:0] tx_valid,
  input logic [1:0] txe,
  input logic [1:0] rxi,
  input logic [1:0] txi,
  input logic [1:0] rxs,
  input logic [1:0] txs,
  input logic [1:0] brk,
  input logic [1:0] crst
);
  for (genvar g = 0; g < 2; g++) begin : g_a
    assert_rx_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[g] && rx_ready[g] && !crst[g]) |=> !rx_ready[g]);
    assert_tx_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid[g] |-> !txe[g]);
    assert_svc_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rxs[g] && txs[g]));
  end
  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxi == 2'b00 && txi == 2'b00 && brk == 2'b00) |-> !irq);
endmodule

bind dual_serial_intc dual_serial_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .txe(txe_v), .rxi(rxi_v), .txi(txi_v), .rxs(rxs_v),
  .txs(txs_v), .brk(brk_v), .crst(crst)
);

// File: tb/sim_dual_serial_intc.sv
`timescale 1ns/1ps
module sim_dual_serial_intc;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] rx_valid = '0, rx_ready, brk_in = '0, tx_valid, tx_done = '0;
  logic [15:0] rx_byte = '0, tx_byte;
  logic irq;
  logic [47:0] baud_div;
  logic [1:0] par_en, par_even, stop_two;
  logic [7:0] data_bits;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] r;

  always #2 clk = ~clk;

  dual_serial_intc u0 (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus(input logic w, input logic ch, input logic d, input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    bus_sel = 1; bus_wr = w; bus_addr = {ch, d}; bus_wdata = wd;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic set_ptr(input logic ch, input int reg_n);
    logic [7:0] t;
    if (reg_n != 0) bus(1, ch, 0, {2'b00, (reg_n >= 8) ? 3'd1 : 3'd0, 3'(reg_n)}, t);
  endtask

  task automatic wr_reg(input logic ch, input int reg_n, input logic [7:0] v);
    logic [7:0] t;
    set_ptr(ch, reg_n);
    bus(1, ch, 0, v, t);
  endtask

  task automatic rd_reg(input logic ch, input int reg_n, output logic [7:0] v);
    set_ptr(ch, reg_n);
    bus(0, ch, 0, 8'h00, v);
  endtask

  task automatic pulse_rx(input int ch, input logic [7:0] b);
    @(negedge clk); rx_valid[ch] = 1; rx_byte[ch*8 +: 8] = b;
    @(negedge clk); rx_valid = '0;
  endtask

  task automatic pulse_done(input int ch);
    @(negedge clk); tx_done[ch] = 1;
    @(negedge clk); tx_done = '0;
  endtask

  task automatic t_reset;
    rd_reg(0, 0, r); check("R2 rr0", r, 8'h44);
    rd_reg(1, 1, r); check("R2 rr1", r, 8'h07);
    rd_reg(0, 2, r); check("R2 vec", r, 8'h00);
    check("R2 irq", irq, 0);
    check("R2 div", baud_div[23:0], 4);
    check("R2 bits", data_bits, 8'h55);
    check("R2 stop/par", {stop_two, par_en}, 0);
    check("R3 ready off", rx_ready, 0);
  endtask

  task automatic t_line;
    wr_reg(0, 12, 8'h10); wr_reg(0, 13, 8'h00);
    wr_reg(0, 4, 8'h44);
    check("R11 div x16", baud_div[23:0], 576);
    check("R11 one stop", stop_two[0], 0);
    wr_reg(0, 4, 8'hCF);
    check("R11 div x64", baud_div[23:0], 2304);
    check("R11 parity", {par_en[0], par_even[0], stop_two[0]}, 3'b111);
    wr_reg(0, 13, 8'h01);
    check("R1 point high", baud_div[23:0], 35072);
    wr_reg(0, 5, 8'h60); check("R11 8 bits", data_bits[3:0], 8);
    wr_reg(0, 5, 8'h20); check("R11 7 bits", data_bits[3:0], 7);
    wr_reg(0, 5, 8'h40); check("R11 6 bits", data_bits[3:0], 6);
    bus(0, 0, 0, 8'h00, r); check("R1 ptr back to 0", r, 8'h44);
  endtask

  task automatic t_rx;
    wr_reg(1, 3, 8'h01); wr_reg(1, 1, 8'h10);
    check("R3 ready on", rx_ready[1], 1);
    pulse_rx(1, 8'h5A);
    check("R3 ready drop", rx_ready[1], 0);
    check("R5 rx irq", irq, 1);
    rd_reg(1, 0, r); check("R3 avail", r, 8'h45);
    rd_reg(1, 3, r); check("R7 pend rxA", r, 8'h20);
    rd_reg(0, 3, r); check("R7 via B zero", r, 8'h00);
    rd_reg(1, 2, r); check("R6 vec rxA lo", r, 8'h0C);
    pulse_rx(1, 8'h11);
    bus(0, 1, 1, 8'h00, r); check("R3 drop second", r, 8'h5A);
    rd_reg(1, 0, r); check("R3 avail clr", r, 8'h44);
    check("R5 irq off", irq, 0);
    rd_reg(1, 2, r); check("R6 none lo", r, 8'h06);
    wr_reg(1, 1, 8'h18);
    pulse_rx(1, 8'h77);
    check("R5 mode 11 no irq", irq, 0);
    bus(0, 1, 1, 8'h00, r); check("R3 read 77", r, 8'h77);
  endtask

  task automatic t_sthi;
    wr_reg(0, 9, 8'h10);
    wr_reg(0, 3, 8'h01); wr_reg(0, 1, 8'h08);
    pulse_rx(0, 8'hA5);
    rd_reg(0, 2, r); check("R6 rxB hi", r, 8'h20);
    rd_reg(1, 3, r); check("R7 pend rxB", r, 8'h04);
    check("R5 irq B", irq, 1);
    bus(0, 0, 1, 8'h00, r); check("R3 read B", r, 8'hA5);
    rd_reg(0, 2, r); check("R6 none hi", r, 8'h60);
  endtask

  task automatic t_lockout;
    wr_reg(1, 5, 8'h08); wr_reg(1, 1, 8'h12);
    bus(1, 1, 1, 8'h33, r);
    check("R4 strobe", tx_valid, 2'b10);
    check("R4 byte", tx_byte[15:8], 8'h33);
    @(negedge clk); check("R4 one cycle", tx_valid, 2'b00);
    rd_reg(1, 0, r); check("R4 txe clr", r, 8'h40);
    rd_reg(1, 1, r); check("R4 sent clr", r, 8'h06);
    pulse_done(1);
    rd_reg(1, 0, r); check("R4 txe set", r, 8'h44);
    rd_reg(1, 1, r); check("R4 sent set", r, 8'h07);
    check("R5 tx irq", irq, 1);
    rd_reg(1, 2, r); check("R6 txA hi", r, 8'h10);
    pulse_rx(1, 8'h99);
    rd_reg(1, 3, r); check("R7 both A", r, 8'h30);
    rd_reg(1, 2, r); check("R6 lockout", r, 8'h10);
    bus(1, 1, 0, 8'h38, r);
    rd_reg(1, 2, r); check("R8 end svc to rx", r, 8'h30);
    rd_reg(1, 3, r); check("R8 tx cleared", r, 8'h20);
    bus(0, 1, 1, 8'h00, r); check("R3 read 99", r, 8'h99);
    rd_reg(1, 2, r); check("R8 none after", r, 8'h60);
    check("R5 irq quiet", irq, 0);
  endtask

  task automatic t_txcmd;
    bus(1, 0, 1, 8'h55, r);
    check("R4 disabled no strobe", tx_valid, 0);
    rd_reg(0, 0, r); check("R4 disabled txe", r, 8'h44);
    wr_reg(0, 5, 8'h08); wr_reg(0, 1, 8'h02);
    bus(1, 0, 1, 8'h66, r);
    check("R4 strobe B", {tx_valid, tx_byte[7:0]}, {2'b01, 8'h66});
    pulse_done(0);
    rd_reg(0, 2, r); check("R6 txB", r, 8'h00);
    rd_reg(1, 3, r); check("R7 pend txB", r, 8'h02);
    check("R5 irq txB", irq, 1);
    bus(1, 0, 0, 8'h28, r);
    check("R8 clr tx irq", irq, 0);
    rd_reg(1, 3, r); check("R8 pend clr", r, 8'h00);
    rd_reg(0, 2, r); check("R8 vec none", r, 8'h60);
  endtask

  task automatic t_break_reset;
    @(negedge clk); brk_in[0] = 1; @(negedge clk); brk_in = '0;
    rd_reg(0, 0, r); check("R10 brk status", r, 8'hC4);
    check("R5 brk masked", irq, 0);
    wr_reg(0, 15, 8'h80);
    check("R5 brk irq", irq, 1);
    wr_reg(1, 5, 8'h68);
    wr_reg(0, 9, 8'h40);
    rd_reg(0, 0, r); check("R10 brk cleared", r, 8'h44);
    check("R9 irq after B rst", irq, 0);
    check("R9 B line", {data_bits[3:0], baud_div[23:0]}, {4'd5, 24'd4});
    check("R9 A kept", data_bits[7:4], 8);
    rd_reg(0, 2, r); check("R9 vec cleared", r, 8'h00);
    wr_reg(0, 9, 8'h80);
    check("R9 A reset", {data_bits[7:4], rx_ready[1]}, {4'd5, 1'b0});
    wr_reg(0, 5, 8'h60); wr_reg(1, 5, 8'h60);
    wr_reg(1, 9, 8'hC0);
    check("R9 both reset", data_bits, 8'h55);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_line();
    t_rx();
    t_sthi();
    t_lockout();
    t_txcmd();
    t_break_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule